// File: doc/BRIEF.md
# Checksum-Gated Configuration Enable Controller

This block sits in front of a decoder's configuration port and decides when the decoder may run. The host writes 32-bit packets. The top byte is a packet identifier and the lower 24 bits are the payload. Each configuration write folds its payload into a running XOR register and locks the decoder. To unlock it, the host sends a checksum packet (identifier zero) whose payload equals that register. In practice the host must return the XOR of every configuration payload written since reset, so any lost, corrupted or unexpected write keeps the decoder locked.

While the decoder is locked, the block also filters the read side. Only the part-identification packet may leave; every other outgoing packet is held back. The host can always send an all-zero word, which is a harmless checksum packet, when it has nothing else to write. The block does not handle how packets are carried, and it does not contain the decoder itself.

Top module: `cfg_gate_top`

## Requirements
- R1: After reset the enable output is 0 and the checksum register is 0, so a checksum packet with payload 0 is the first one that enables.
- R2: A packet whose identifier (bits 31:24) is in the range 1 to 0x1F is a configuration packet. It XORs bits 23:0 into the checksum register and clears the enable output.
- R3: A checksum packet (bits 31:24 equal to 0) received while disabled sets the enable output only when bits 23:0 equal the checksum register. Otherwise the block stays disabled.
- R4: A checksum packet received while enabled changes neither the enable output nor the checksum register.
- R5: A packet with an identifier above 0x1F clears the enable output and leaves the checksum register unchanged.
- R6: The all-zero 32-bit word never clears the enable output.
- R7: The read-side allow output is 1 when the block is enabled, or when the outgoing identifier equals the PART_ID parameter (default 0x3F). In every other case it is 0.
- R8: A successful enable does not clear the checksum register. Later configuration payloads keep accumulating onto it.
- R9: State changes only on a clock edge where pkt_valid is 1, and the new enable value appears in the cycle after that edge. With pkt_valid at 0, the enable output holds its value whatever pkt_word carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | One packet is presented this cycle |
| pkt_word | input | 32 | Packet: identifier in 31:24, payload in 23:0 |
| rd_pkt_id | input | 8 | Identifier of the packet the decoder wants to send out |
| dec_enable | output | 1 | Decoder enabled |
| rd_allow | output | 1 | Outgoing packet may be released |

## Verification
The hardest case to reach is showing that the checksum register keeps its value, because the register is not visible at the ports. Two situations need this: the register is left alone by a checksum packet sent while enabled and by packets with out-of-range identifiers, and it is not cleared when the block enables. The stimulus therefore follows each such event with a lock and a checksum packet. That checksum carries the XOR of all configuration payloads since reset, so the block re-enables only if the register kept exactly that value. Deliberately wrong checksums are also sent, including the value a register cleared on enable would hold, and each must leave the block locked.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
    localparam int ID_W  = 8;
    localparam int PAY_W = 24;
    localparam int PKT_W = ID_W + PAY_W;

    typedef enum logic [1:0] {
        KIND_CHECK  = 2'd0,
        KIND_CONFIG = 2'd1,
        KIND_OTHER  = 2'd2
    } pkt_kind_e;

    typedef struct packed {
        logic [PAY_W-1:0] sum;
        logic             en;
    } gate_state_t;
endpackage

// File: rtl/cfg_pkt_classify.sv
module cfg_pkt_classify
    import cfg_gate_pkg::*;
#(
    parameter logic [ID_W-1:0] CFG_ID_MAX = 8'h1F
) (
    input  logic [PKT_W-1:0] word_i,
    output pkt_kind_e        kind_o,
    output logic [PAY_W-1:0] payload_o
);
    logic [ID_W-1:0] id;

    always_comb begin
        id        = word_i[PKT_W-1:PAY_W];
        payload_o = word_i[PAY_W-1:0];
        if (id == '0) begin
            kind_o = KIND_CHECK;
        end else if (id <= CFG_ID_MAX) begin
            kind_o = KIND_CONFIG;
        end else begin
            kind_o = KIND_OTHER;
        end
    end
endmodule

// File: rtl/cfg_sum_state.sv
module cfg_sum_state
    import cfg_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  pkt_kind_e        kind_i,
    input  logic [PAY_W-1:0] payload_i,
    output logic             en_o
);
    gate_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            unique case (kind_i)
                KIND_CHECK: begin
                    if (!state_q.en && payload_i == state_q.sum) begin
                        state_d.en = 1'b1;
                    end
                end
                KIND_CONFIG: begin
                    state_d.sum = state_q.sum ^ payload_i;
                    state_d.en  = 1'b0;
                end
                default: begin
                    state_d.en = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o = state_q.en;

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(state_q));

    assert_ck_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && kind_i == KIND_CHECK && !state_q.en && payload_i == state_q.sum |=> state_q.en);

    assert_ck_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && kind_i == KIND_CHECK && !state_q.en && payload_i != state_q.sum
        |=> !state_q.en && $stable(state_q.sum));

    assert_ck_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && kind_i == KIND_CHECK && state_q.en |=> $stable(state_q));

    assert_other_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && kind_i == KIND_OTHER |=> !state_q.en && $stable(state_q.sum));

    assert_cfg_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && kind_i == KIND_CONFIG |=> state_q.sum == ($past(state_q.sum) ^ $past(payload_i)));
endmodule

// File: rtl/cfg_read_gate.sv
module cfg_read_gate
    import cfg_gate_pkg::*;
#(
    parameter logic [ID_W-1:0] PART_ID = 8'h3F
) (
    input  logic            en_i,
    input  logic [ID_W-1:0] rd_id_i,
    output logic            allow_o
);
    always_comb begin
        allow_o = en_i || (rd_id_i == PART_ID);
        assert_gate_block_R7: assert (en_i || rd_id_i == PART_ID || !allow_o);
    end
endmodule

// File: rtl/cfg_gate_top.sv
module cfg_gate_top
    import cfg_gate_pkg::*;
#(
    parameter logic [ID_W-1:0] CFG_ID_MAX = 8'h1F,
    parameter logic [ID_W-1:0] PART_ID    = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_word,
    input  logic [ID_W-1:0]  rd_pkt_id,
    output logic             dec_enable,
    output logic             rd_allow
);
    pkt_kind_e        kind;
    logic [PAY_W-1:0] payload;

    cfg_pkt_classify #(.CFG_ID_MAX(CFG_ID_MAX)) u_classify (
        .word_i    (pkt_word),
        .kind_o    (kind),
        .payload_o (payload)
    );

    cfg_sum_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (pkt_valid),
        .kind_i    (kind),
        .payload_i (payload),
        .en_o      (dec_enable)
    );

    cfg_read_gate #(.PART_ID(PART_ID)) u_gate (
        .en_i    (dec_enable),
        .rd_id_i (rd_pkt_id),
        .allow_o (rd_allow)
    );

    assert_cfg_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_word[31:24] != 8'h00 && pkt_word[31:24] <= CFG_ID_MAX |=> !dec_enable);

    assert_zero_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_word == 32'h0 && dec_enable |=> dec_enable);
endmodule

// File: tb/cfg_gate_top_tb.sv
module cfg_gate_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PART = 8'h3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [31:0] pkt_word = '0;
    logic [7:0]  rd_pkt_id = '0;
    logic        dec_enable, rd_allow;

    int checks = 0;
    int fails = 0;

    logic        exp_q[$];
    string       tag_q[$];
    logic        m_en = 1'b0;
    logic [23:0] m_sum = '0;
    logic        seen_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_gate_top u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
        .rd_pkt_id(rd_pkt_id), .dec_enable(dec_enable), .rd_allow(rd_allow)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Driver: model the requirements, queue the expected enable, present the packet.
    task automatic send(input logic [31:0] w, input string tag);
        logic [7:0] id;
        id = w[31:24];
        if (id == 8'h00) begin
            if (!m_en && w[23:0] == m_sum) m_en = 1'b1;
        end else if (id <= 8'h1F) begin
            m_sum = m_sum ^ w[23:0];
            m_en  = 1'b0;
        end else begin
            m_en = 1'b0;
        end
        exp_q.push_back(m_en);
        tag_q.push_back(tag);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_word  = w;
        @(negedge clk);
        pkt_valid = 1'b0;
        pkt_word  = 32'hA5A5_5A5A;
    endtask

    // Monitor: each accepted packet produces one comparison the next cycle.
    always @(posedge clk) seen_valid <= pkt_valid && rst_n;
    always @(negedge clk) begin
        if (seen_valid && exp_q.size() > 0) begin
            check(tag_q.pop_front(), dec_enable, exp_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [23:0] a, b, c, e;
        a = 24'h12_3456; b = 24'hF0_0F0F; c = 24'h00_00FF; e = 24'h80_0001;
        repeat (3) @(negedge clk);
        check("R1 reset enable", dec_enable, 1'b0);
        rd_pkt_id = PART;  #1 check("R7 part id passes while locked", rd_allow, 1'b1);
        rd_pkt_id = 8'h05; #1 check("R7 other id held while locked", rd_allow, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        send(32'h0000_0000, "R1 zero checksum enables after reset");
        @(negedge clk);
        rd_pkt_id = 8'h05; #1 check("R7 other id passes while enabled", rd_allow, 1'b1);
        send(32'h0000_0000, "R6 zero word keeps enable");
        send(32'h0000_0000, "R6 second zero word keeps enable");

        send({8'h01, a}, "R2 config id 1 locks");
        @(negedge clk);
        rd_pkt_id = 8'h05; #1 check("R7 other id held after lock", rd_allow, 1'b0);
        send({8'h1F, b}, "R2 config id 0x1F locks");
        send({8'h00, a}, "R3 wrong checksum stays locked");
        send({8'h00, a ^ b}, "R3 matching checksum enables");

        send({8'h00, 24'h77_7777}, "R4 checksum while enabled ignored");
        send({8'h10, c}, "R2 config id 0x10 locks");
        send({8'h00, c}, "R8 register not cleared on enable");
        send({8'h00, a ^ b ^ c}, "R4 R8 accumulated checksum enables");

        send({8'h40, e}, "R5 high id locks");
        send({8'h00, a ^ b ^ c ^ e}, "R5 high id payload not folded");
        send({8'h00, a ^ b ^ c}, "R5 register unchanged re-enables");

        // Idle cycles with garbage on the word must not disturb the state.
        @(negedge clk);
        pkt_word = 32'h0100_0001;
        repeat (3) @(negedge clk);
        check("R9 idle holds enable", dec_enable, 1'b1);
        pkt_word = 32'h4000_0000;
        @(negedge clk);
        check("R9 idle ignores high id word", dec_enable, 1'b1);

        send({8'h02, 24'h00_0000}, "R2 zero payload still locks");
        send({8'h00, a ^ b ^ c}, "R2 zero payload leaves register");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule